// File: doc/BRIEF.md
# Framebuffer Control and Status Register Window

This block is the 32-byte register window of a framebuffer controller. It holds a control byte whose top bit enables interrupts, and a status byte. A status read reports fixed board and monitor identity bits together with an interrupt-pending flag. Fourteen more byte slots hold scratch or timing values that software reads back unchanged.

The display engine sends a one-cycle frame-end strobe. When interrupts are enabled, that strobe sets the pending flag, and a registered level interrupt line follows the flag. Software clears the interrupt by writing the status byte, and the data it writes does not matter. The lower half of the window has no registers here. It reads as zero and ignores writes.

Reads have no side effects. Read data follows the address combinationally. A write is taken on the rising clock edge while the write strobe is high.

Top module: `fbc_regwin`

## Requirements
- R1: Offset 0x10 is the control byte. A write stores all 8 bits, and a read returns them unchanged.
- R2: A read of offset 0x11 returns 0x61 ORed with the pending flag in bit 7. It gives 0x61 when nothing is pending and 0xE1 when an interrupt is pending.
- R3: A frame-end strobe while control bit 7 is 1 sets the pending flag. `irq` is high from the clock edge that samples the strobe.
- R4: A frame-end strobe while control bit 7 is 0 leaves the pending flag and `irq` unchanged.
- R5: Any write to offset 0x11 clears the pending flag and lowers `irq` at that edge, whatever the data written. A write with bit 7 set never sets the flag.
- R6: Offsets 0x12 to 0x1F are independent byte registers at slot (offset − 0x10). Each reads back the last value written to it.
- R7: Offsets 0x00 to 0x0F read as zero. Writes to them change no register in the window.
- R8: A frame-end strobe with interrupts enabled may land on the same edge as a status write. The set wins, and the flag stays or becomes 1.
- R9: After reset, `irq` is low, the control byte and all byte registers are zero, and status reads 0x61.
- R10: `irq` always equals status bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Byte offset within the window |
| reg_wr | input | 1 | Write strobe, taken on the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| frame_end | input | 1 | One-cycle end-of-frame strobe from the display engine |
| irq | output | 1 | Level interrupt, registered |

## Verification
The bench builds the block with its default parameters: 8-bit data and a 5-bit offset. This gives a lower half of 16 dead slots and an upper half of 16 live slots. Every offset is reachable, including the lowest and highest byte-register slots and the dead offsets 0x00, 0x08 and 0x0F. The bench can therefore detect a write that aliases from the dead half into the live half. The clear-versus-set collision is forced on a single edge, and the data written to status is varied so that a data-dependent clear shows up.

// File: rtl/fbc_pkg.sv
package fbc_pkg;
    localparam int FBC_DATA_W   = 8;
    localparam int FBC_ADDR_W   = 5;
    localparam int FBC_CTRL_IDX = 0;
    localparam int FBC_STAT_IDX = 1;
    localparam int FBC_IE_BIT   = 7;
    localparam int FBC_PEND_BIT = 7;
    localparam logic [FBC_DATA_W-1:0] FBC_ID_BITS = 8'h61;

    typedef struct packed {
        logic pend;
        logic irq;
    } fbc_irq_st_t;
endpackage

// File: rtl/fbc_decode.sv
module fbc_decode #(
    parameter int ADDR_W = fbc_pkg::FBC_ADDR_W,
    parameter int NREG   = 2 ** (ADDR_W - 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           addr,
    input  logic                        wr,
    output logic                        bank_hit,
    output logic [ADDR_W-2:0]           bank_idx,
    output logic [NREG-1:0]             bank_we
);
    localparam int IDX_W = ADDR_W - 1;

    assign bank_hit = addr[ADDR_W-1];
    assign bank_idx = addr[IDX_W-1:0];

    for (genvar i = 0; i < NREG; i++) begin : g_we
        assign bank_we[i] = wr && bank_hit && (bank_idx == IDX_W'(i));
    end

    // R7: nothing in the live half is written from a lower-half offset
    p_dead_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !addr[ADDR_W-1] |-> (bank_we == '0));
    p_single_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_we));
endmodule

// File: rtl/fbc_reg_bank.sv
module fbc_reg_bank #(
    parameter int DATA_W   = fbc_pkg::FBC_DATA_W,
    parameter int NREG     = 16,
    parameter int SKIP_IDX = fbc_pkg::FBC_STAT_IDX
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NREG-1:0]               we,
    input  logic [DATA_W-1:0]             wdata,
    output logic [NREG-1:0][DATA_W-1:0]   regs
);
    for (genvar i = 0; i < NREG; i++) begin : g_slot
        if (i == SKIP_IDX) begin : g_none
            assign regs[i] = '0;
        end else begin : g_store
            logic [DATA_W-1:0] slot_d, slot_q;

            always_comb begin
                slot_d = slot_q;
                if (we[i]) slot_d = wdata;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) slot_q <= '0;
                else        slot_q <= slot_d;
            end

            assign regs[i] = slot_q;

            p_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
                we[i] |=> (regs[i] == $past(wdata)));
            p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
                !we[i] |=> $stable(regs[i]));
        end
    end
endmodule

// File: rtl/fbc_irq_ctrl.sv
module fbc_irq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_end,
    input  logic int_en,
    input  logic stat_we,
    output logic pend,
    output logic irq
);
    import fbc_pkg::*;

    fbc_irq_st_t st_d, st_q;
    logic        set_req;

    always_comb begin
        set_req = frame_end && int_en;
        st_d    = st_q;
        if (set_req)      st_d.pend = 1'b1;   // set wins over clear
        else if (stat_we) st_d.pend = 1'b0;
        st_d.irq = st_d.pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;
    assign irq  = st_q.irq;

    p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && int_en) |=> (pend && irq));
    p_disabled_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!(frame_end && int_en) && !stat_we) |=> $stable(pend));
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we && !(frame_end && int_en)) |=> !irq);
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we && frame_end && int_en) |=> irq);
    p_irq_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq == pend);
endmodule

// File: rtl/fbc_regwin.sv
module fbc_regwin #(
    parameter int DATA_W = fbc_pkg::FBC_DATA_W,
    parameter int ADDR_W = fbc_pkg::FBC_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              frame_end,
    output logic              irq
);
    import fbc_pkg::*;

    localparam int NREG  = 2 ** (ADDR_W - 1);
    localparam int IDX_W = ADDR_W - 1;

    logic                          bank_hit;
    logic [IDX_W-1:0]              bank_idx;
    logic [NREG-1:0]               bank_we;
    logic [NREG-1:0][DATA_W-1:0]   regs;
    logic                          pend;
    logic [DATA_W-1:0]             stat_view;

    fbc_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (reg_addr),
        .wr       (reg_wr),
        .bank_hit (bank_hit),
        .bank_idx (bank_idx),
        .bank_we  (bank_we)
    );

    fbc_reg_bank #(.DATA_W(DATA_W), .NREG(NREG), .SKIP_IDX(FBC_STAT_IDX)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bank_we),
        .wdata (reg_wdata),
        .regs  (regs)
    );

    fbc_irq_ctrl u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_end (frame_end),
        .int_en    (regs[FBC_CTRL_IDX][FBC_IE_BIT]),
        .stat_we   (bank_we[FBC_STAT_IDX]),
        .pend      (pend),
        .irq       (irq)
    );

    always_comb begin
        stat_view               = FBC_ID_BITS;
        stat_view[FBC_PEND_BIT] = pend;
        reg_rdata               = '0;
        if (bank_hit) begin
            if (bank_idx == IDX_W'(FBC_STAT_IDX)) reg_rdata = stat_view;
            else                                   reg_rdata = regs[bank_idx];
        end
    end

    p_status_id_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(NREG + FBC_STAT_IDX)) |->
            ((reg_rdata & ~FBC_ID_BITS) == {pend, {(DATA_W-1){1'b0}}}
             && (reg_rdata & FBC_ID_BITS) == FBC_ID_BITS));
    p_low_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_addr[ADDR_W-1] |-> (reg_rdata == '0));
endmodule

// File: tb/fbc_regwin_tb_top.sv
module fbc_regwin_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       frame_end = 1'b0;
    logic       irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    fbc_regwin dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .frame_end(frame_end), .irq(irq)
    );

    // {offset, write data, expected read-back}
    localparam int NVEC = 9;
    localparam logic [20:0] VEC [NVEC] = '{
        {5'h10, 8'hA5, 8'hA5},   // R1
        {5'h12, 8'h3C, 8'h3C},   // R6 lowest slot
        {5'h1F, 8'hC3, 8'hC3},   // R6 highest slot
        {5'h15, 8'hFF, 8'hFF},   // R6
        {5'h08, 8'h77, 8'h00},   // R7
        {5'h00, 8'h55, 8'h00},   // R7
        {5'h0F, 8'h12, 8'h00},   // R7
        {5'h11, 8'hFF, 8'h61},   // R2, R5: data bit 7 does not set
        {5'h13, 8'h00, 8'h00}    // R6
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse_fe();
        @(negedge clk);
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        check("R9 irq", {7'b0, irq}, 8'h00);
        rd(5'h10, v); check("R9 ctrl", v, 8'h00);
        rd(5'h11, v); check("R9 status", v, 8'h61);
        rd(5'h1A, v); check("R9 bank", v, 8'h00);

        for (int k = 0; k < NVEC; k++) begin
            wr(VEC[k][20:16], VEC[k][15:8]);
            rd(VEC[k][20:16], v);
            check($sformatf("R1/R2/R6/R7 vec%0d", k), v, VEC[k][7:0]);
        end
        // R7: dead-half writes left the live slots intact
        rd(5'h10, v); check("R7 ctrl kept", v, 8'hA5);
        rd(5'h18, v); check("R7 slot 0x18 kept", v, 8'h00);
        rd(5'h1F, v); check("R7 slot 0x1F kept", v, 8'hC3);

        // R3 set with enable, R10 irq equals status bit 7
        wr(5'h10, 8'h80);
        pulse_fe();
        check("R3 irq", {7'b0, irq}, 8'h01);
        rd(5'h11, v); check("R2 status pending", v, 8'hE1);
        check("R10 irq vs status", {7'b0, irq}, {7'b0, v[7]});

        // R5 clear with zero data, then with bit 7 set
        wr(5'h11, 8'h00);
        check("R5 clear data 00", {7'b0, irq}, 8'h00);
        pulse_fe();
        wr(5'h11, 8'h80);
        check("R5 clear data 80", {7'b0, irq}, 8'h00);
        rd(5'h11, v); check("R5 status after clear", v, 8'h61);

        // R4 disabled: no set; also other control bits do not enable
        wr(5'h10, 8'h7F);
        pulse_fe();
        check("R4 no set", {7'b0, irq}, 8'h00);
        rd(5'h11, v); check("R4 status", v, 8'h61);

        // R8 collision: set and clear on one edge
        wr(5'h10, 8'h80);
        @(negedge clk);
        frame_end = 1'b1; reg_addr = 5'h11; reg_wdata = 8'h00; reg_wr = 1'b1;
        @(negedge clk);
        frame_end = 1'b0; reg_wr = 1'b0;
        check("R8 set wins", {7'b0, irq}, 8'h01);
        rd(5'h11, v); check("R8 status", v, 8'hE1);

        // R9 reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R9 irq after reset", {7'b0, irq}, 8'h00);
        rd(5'h10, v); check("R9 ctrl after reset", v, 8'h00);
        rd(5'h12, v); check("R9 slot after reset", v, 8'h00);

        finish_run();
    end
endmodule